// File: doc/BRIEF.md
# Signed-Digit Decimal Partial Product Selector

This combinational block forms the partial-product array of a parallel decimal multiplier. It recodes a D-digit BCD multiplier into signed base-10 digits of magnitude at most five. For each recoded digit it picks the matching multiplicand multiple (1X to 5X), which an external generator supplies in excess-3 code, and inverts every bit of it for a negative digit. Bit inversion of an excess-3 digit yields the excess-3 code of its nine's complement, so no subtractor is needed.

The outputs are D+1 rows of D+1 four-bit digits each. The top digit of every row carries a bias of +8, so every row stays a non-negative overloaded decimal word. A negative row also raises a separate weight-one bit that completes the ten's complement. The block also supplies one constant correction word that removes all the biases. A downstream reduction tree adds the rows, the hot bits and the correction word. What it receives is the product modulo 10^(2D+1).

Top module: `sdpp_selector`

## Requirements
- R1: Recoding runs from the least significant multiplier digit upward. With v = digit + incoming transfer, v of 6 or more gives recoded digit v-10 and an outgoing transfer of 1, and otherwise the recoded digit is v with no transfer. A v of exactly 5 stays +5 when FIVE_POS=1 (the default) and becomes -5 with a transfer when FIVE_POS=0.
- R2: Row k (k = 0..D-1) sits at bits [k*4*(D+1) +: 4*(D+1)] of `pp_rows`, digit j at 4*j within the row, and digit D is the top digit. For a positive nonzero recoded digit of magnitude m, digits 0..D-1 equal multiple m, which is taken from `mult_xs3[(m-1)*4*D +: 4*D]`.
- R3: For a negative recoded digit, every bit of the selected body digits is inverted and `neg_one[k]` is 1. Otherwise `neg_one[k]` is 0.
- R4: A recoded digit of zero yields body digits of code 3 each, a top digit of code 8 and `neg_one` 0.
- R5: The top digit is 8+T for a positive row and 7-T for a negative row. T is the 3-bit carry of the selected multiple, at `mult_carry[3*(m-1) +: 3]`. So with T in 0..4 the top digit lies in 3..12, and its MSB is the inverted sign.
- R6: Row D takes the final recoding transfer. It holds a positive 1X when the transfer is 1 and the zero pattern when it is 0, and `neg_one[D]` is always 0.
- R7: `corr_bcd` holds 2D+1 BCD digits. Their value is 10^(2D+1) minus the sum of all row biases (8 at each top position and 3 at each body position), taken modulo 10^(2D+1). For valid multiples, the sum of all row digit codes weighted by position, plus the hot bits, plus `corr_bcd`, equals multiplicand times multiplier modulo 10^(2D+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mplr_bcd | input | 4*D | Multiplier, BCD, digit 0 in the low nibble |
| mult_xs3 | input | 5*4*D | Multiples 1X..5X, excess-3 digits |
| mult_carry | input | 15 | Top carry T of each multiple, 3 bits each |
| pp_rows | output | (D+1)*4*(D+1) | D+1 partial-product rows |
| neg_one | output | D+1 | Ten's-complement hot bit per row, weight 10^k |
| corr_bcd | output | 4*(2D+1) | Bias correction word, BCD |

## Verification
The hardest case is a carry that ripples through the whole recoding chain. Runs of nines and of sixes or more must push a transfer through every position into the extra row, and a 9 that absorbs a transfer must turn into a positive zero. Directed multipliers of 9999, 6666, 5555 and mixed 4/5 patterns drive these chains. Random multipliers paired with true multiples of a random multiplicand then check the full product identity through the correction word. Random arbitrary digit codes exercise selection and inversion apart from arithmetic validity.

// File: rtl/sdpp_pkg.sv
// Package: shared constants for the signed-digit partial product selector.
// Assumes four-bit digits and a multiple set of exactly 1X..5X.
package sdpp_pkg;
    localparam int DIG_W    = 4;   // bits per decimal digit
    localparam int N_MULT   = 5;   // number of selectable multiples
    localparam int CARRY_W  = 3;   // bits of a multiple's top carry
    localparam logic [3:0] XS3_ZERO = 4'd3; // excess-3 code of zero
endpackage

// File: rtl/sdpp_recoder.sv
// Module: sdpp_recoder
// Recodes a D-digit BCD multiplier into signed digits in [-5,5], each given
// as a one-hot magnitude selector (bit m-1 for magnitude m) plus a sign.
// Assumes BCD-valid input digits. FIVE_POS picks how a value of 5 is kept.
module sdpp_recoder
    import sdpp_pkg::*;
#(
    parameter int D        = 4,
    parameter bit FIVE_POS = 1'b1
) (
    input  logic [DIG_W*D-1:0]  mplr_bcd,
    output logic [N_MULT*D-1:0] sel_oh,
    output logic [D-1:0]        sel_neg,
    output logic                carry_top
);
    localparam logic [4:0] NEG_FROM = FIVE_POS ? 5'd6 : 5'd5;

    logic [D:0] xfer;
    assign xfer[0]   = 1'b0;
    assign carry_top = xfer[D];

    for (genvar i = 0; i < D; i++) begin : g_dig
        logic [4:0] v;
        logic [4:0] mag;
        logic       big;

        // Per-position value, transfer decision and one-hot magnitude.
        always_comb begin
            v   = {1'b0, mplr_bcd[DIG_W*i +: DIG_W]} + {4'd0, xfer[i]};
            big = (v >= NEG_FROM);
            mag = big ? (5'd10 - v) : v;
            sel_oh[N_MULT*i +: N_MULT] = '0;
            for (int m = 1; m <= N_MULT; m++) begin
                if (mag == 5'(m)) sel_oh[N_MULT*i + m - 1] = 1'b1;
            end
            sel_neg[i]  = big && (mag != 5'd0);
            xfer[i+1]   = big;
        end

        // Guards on the selector of this position.
        always_comb begin
            assert_sel_onehot_R1: assert ($onehot0(sel_oh[N_MULT*i +: N_MULT]))
                else $error("recoded selector not one-hot");
            assert_zero_positive_R4: assert (!(sel_neg[i] && sel_oh[N_MULT*i +: N_MULT] == '0))
                else $error("zero digit carries a negative sign");
            assert_five_policy_R1: assert (!(sel_oh[N_MULT*i + 4] && (sel_neg[i] == FIVE_POS)))
                else $error("magnitude five with the excluded sign");
        end
    end
endmodule

// File: rtl/sdpp_row_sel.sv
// Module: sdpp_row_sel
// Builds one partial-product row: one-hot pick of an excess-3 multiple,
// bit inversion for a negative digit, and the biased top digit.
// Assumes sel_oh is one-hot or zero and that zero comes with neg = 0.
module sdpp_row_sel
    import sdpp_pkg::*;
#(
    parameter int D = 4
) (
    input  logic [N_MULT-1:0]               sel_oh,
    input  logic                            neg,
    input  logic [N_MULT*DIG_W*D-1:0]       mult_xs3,
    input  logic [N_MULT*CARRY_W-1:0]       mult_carry,
    output logic [DIG_W*(D+1)-1:0]          row_code,
    output logic                            hot_one
);
    localparam int BW = DIG_W * D;

    logic [BW-1:0]      pick_body;
    logic [CARRY_W-1:0] pick_top;
    logic [DIG_W-1:0]   top_code;

    // One-hot multiplexer; an empty selector gives the excess-3 zero.
    always_comb begin
        pick_body = '0;
        pick_top  = '0;
        if (sel_oh == '0) begin
            for (int j = 0; j < D; j++) pick_body[DIG_W*j +: DIG_W] = XS3_ZERO;
        end else begin
            for (int m = 0; m < N_MULT; m++) begin
                if (sel_oh[m]) begin
                    pick_body = pick_body | mult_xs3[m*BW +: BW];
                    pick_top  = pick_top  | mult_carry[CARRY_W*m +: CARRY_W];
                end
            end
        end
    end

    // Conditional inversion and biased top digit (8+T or 7-T).
    always_comb begin
        top_code = {~neg, pick_top ^ {CARRY_W{neg}}};
        row_code = {top_code, pick_body ^ {BW{neg}}};
        hot_one  = neg;
    end

    // Top digit stays in the overloaded range for legal carries.
    always_comb begin
        if (pick_top <= 3'd4) begin
            assert_top_range_R5: assert (top_code >= 4'd3 && top_code <= 4'd12)
                else $error("top digit out of range");
        end
        assert_top_msb_R5: assert (top_code[3] == !hot_one)
            else $error("top digit MSB disagrees with sign");
    end
endmodule

// File: rtl/sdpp_selector.sv
// Module: sdpp_selector (top)
// Recodes the multiplier, builds D+1 partial-product rows from externally
// generated excess-3 multiples, and supplies the bias correction word.
// Assumes multiples arrive with top carries in 0..4; purely combinational.
module sdpp_selector
    import sdpp_pkg::*;
#(
    parameter int D        = 4,
    parameter bit FIVE_POS = 1'b1
) (
    input  logic [DIG_W*D-1:0]               mplr_bcd,
    input  logic [N_MULT*DIG_W*D-1:0]        mult_xs3,
    input  logic [N_MULT*CARRY_W-1:0]        mult_carry,
    output logic [(D+1)*DIG_W*(D+1)-1:0]     pp_rows,
    output logic [D:0]                       neg_one,
    output logic [DIG_W*(2*D+1)-1:0]         corr_bcd
);
    localparam int ROW_W = DIG_W * (D + 1);
    localparam int CD    = 2 * D + 1;

    // Ten's complement of all row biases, as CD BCD digits.
    function automatic logic [DIG_W*CD-1:0] make_corr();
        int s [CD];
        int c;
        int t;
        logic [DIG_W*CD-1:0] r;
        for (int p = 0; p < CD; p++) begin
            s[p] = 0;
            for (int k = 0; k <= D; k++) begin
                if (p >= k && p <= k + D - 1) s[p] = s[p] + 3;
                if (p == k + D)               s[p] = s[p] + 8;
            end
        end
        c = 0;
        for (int p = 0; p < CD; p++) begin
            t    = s[p] + c;
            s[p] = t % 10;
            c    = t / 10;
        end
        c = 1;
        for (int p = 0; p < CD; p++) begin
            t    = (9 - s[p]) + c;
            r[DIG_W*p +: DIG_W] = 4'(t % 10);
            c    = t / 10;
        end
        return r;
    endfunction

    localparam logic [DIG_W*CD-1:0] CORR = make_corr();

    logic [N_MULT*D-1:0] sel_oh;
    logic [D-1:0]        sel_neg;
    logic                carry_top;

    sdpp_recoder #(.D(D), .FIVE_POS(FIVE_POS)) u_rec (
        .mplr_bcd (mplr_bcd),
        .sel_oh   (sel_oh),
        .sel_neg  (sel_neg),
        .carry_top(carry_top)
    );

    for (genvar k = 0; k <= D; k++) begin : g_row
        logic [N_MULT-1:0] row_sel;
        logic              row_neg;
        if (k < D) begin : g_main
            assign row_sel = sel_oh[N_MULT*k +: N_MULT];
            assign row_neg = sel_neg[k];
        end else begin : g_extra
            assign row_sel = {{(N_MULT-1){1'b0}}, carry_top};
            assign row_neg = 1'b0;
        end
        sdpp_row_sel #(.D(D)) u_row (
            .sel_oh    (row_sel),
            .neg       (row_neg),
            .mult_xs3  (mult_xs3),
            .mult_carry(mult_carry),
            .row_code  (pp_rows[ROW_W*k +: ROW_W]),
            .hot_one   (neg_one[k])
        );
    end

    assign corr_bcd = CORR;

    // Extra row is never negative.
    always_comb begin
        assert_extra_row_pos_R6: assert (!neg_one[D])
            else $error("extra row flagged negative");
    end
endmodule

// File: tb/sdpp_selector_tb.sv
// Bench for sdpp_selector: directed multipliers plus seeded random ones,
// against expected rows and the product identity computed here.
module sdpp_selector_tb;
    localparam int D  = 4;
    localparam int RW = 4 * (D + 1);
    localparam int BW = 4 * D;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [BW-1:0]          mplr_bcd;
    logic [5*BW-1:0]        mult_xs3;
    logic [14:0]            mult_carry;
    logic [(D+1)*RW-1:0]    pp_rows;
    logic [D:0]             neg_one;
    logic [4*(2*D+1)-1:0]   corr_bcd;

    sdpp_selector #(.D(D)) u_dut (
        .mplr_bcd  (mplr_bcd),
        .mult_xs3  (mult_xs3),
        .mult_carry(mult_carry),
        .pp_rows   (pp_rows),
        .neg_one   (neg_one),
        .corr_bcd  (corr_bcd)
    );

    int n_checks = 0;
    int n_errors = 0;
    int rmag [D+1];
    bit rneg [D+1];
    bit done = 1'b0;

    task automatic check(string tag, longint act, longint exp_v, string what);
        n_checks++;
        if (act != exp_v) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp_v);
        end
    endtask

    function automatic longint p10(int n);
        longint r = 1;
        for (int i = 0; i < n; i++) r = r * 10;
        return r;
    endfunction

    // Bench recoding per R1 (FIVE_POS = 1).
    task automatic recode(logic [BW-1:0] y);
        int t = 0;
        for (int j = 0; j < D; j++) begin
            int v = int'(y[4*j +: 4]) + t;
            if (v >= 6) begin
                rmag[j] = 10 - v; rneg[j] = (v != 10); t = 1;
            end else begin
                rmag[j] = v; rneg[j] = 1'b0; t = 0;
            end
        end
        rmag[D] = t; rneg[D] = 1'b0;
    endtask

    // Loads true excess-3 multiples of a BCD-valued multiplicand.
    task automatic load_mults(int x);
        for (int n = 1; n <= 5; n++) begin
            int p = n * x;
            for (int j = 0; j < D; j++)
                mult_xs3[(n-1)*BW + 4*j +: 4] = 4'(((p / int'(p10(j))) % 10) + 3);
            mult_carry[3*(n-1) +: 3] = 3'(p / int'(p10(D)));
        end
    endtask

    function automatic int to_bcd_int(int v);
        return v;
    endfunction

    // Compares every row and hot bit against the bench model.
    task automatic check_rows(string force_tag);
        for (int k = 0; k <= D; k++) begin
            logic [RW-1:0] exp_row;
            logic [3:0]    t;
            string tag;
            if (rmag[k] == 0) begin
                for (int j = 0; j < D; j++) exp_row[4*j +: 4] = 4'd3;
                t = 4'd0;
            end else begin
                exp_row[BW-1:0] = mult_xs3[(rmag[k]-1)*BW +: BW];
                t = {1'b0, mult_carry[3*(rmag[k]-1) +: 3]};
            end
            if (rneg[k]) begin
                exp_row[BW-1:0] = ~exp_row[BW-1:0];
                exp_row[RW-1:BW] = 4'd7 - t;
            end else begin
                exp_row[RW-1:BW] = 4'd8 + t;
            end
            if (force_tag != "")      tag = force_tag;
            else if (k == D)          tag = "R6";
            else if (rmag[k] == 0)    tag = "R4";
            else if (rneg[k])         tag = "R3";
            else                      tag = "R2";
            check(tag, longint'(pp_rows[RW*k +: BW]), longint'(exp_row[BW-1:0]),
                  $sformatf("row %0d body", k));
            check("R5", longint'(pp_rows[RW*k + BW +: 4]), longint'(exp_row[RW-1:BW]),
                  $sformatf("row %0d top", k));
            check("R3", longint'(neg_one[k]), longint'(rneg[k]),
                  $sformatf("row %0d hot bit", k));
        end
    endtask

    // Product identity through the correction word (R7).
    task automatic check_product(int x, int y);
        longint m = p10(2*D+1);
        longint acc = 0;
        for (int k = 0; k <= D; k++) begin
            for (int j = 0; j <= D; j++)
                acc += longint'(pp_rows[RW*k + 4*j +: 4]) * p10(k + j);
            acc += longint'(neg_one[k]) * p10(k);
        end
        for (int p = 0; p < 2*D+1; p++)
            acc += longint'(corr_bcd[4*p +: 4]) * p10(p);
        check("R7", acc % m, longint'(x) * longint'(y), $sformatf("product %0d*%0d", x, y));
    endtask

    function automatic logic [BW-1:0] dec2bcd(int v);
        logic [BW-1:0] r;
        for (int j = 0; j < D; j++) r[4*j +: 4] = 4'((v / int'(p10(j))) % 10);
        return r;
    endfunction

    task automatic run_valid(int x, int y, string force_tag);
        @(posedge clk);
        mplr_bcd = dec2bcd(y);
        load_mults(x);
        recode(mplr_bcd);
        #2;
        check_rows(force_tag);
        check_product(x, y);
    endtask

    initial begin
        int seed_dummy;
        longint s;
        logic [4*(2*D+1)-1:0] exp_corr;
        seed_dummy = $urandom(32'd1234);
        mplr_bcd = '0; mult_xs3 = '0; mult_carry = '0;
        #2;
        // Correction word, R7: 10^9 - biases.
        s = 0;
        for (int k = 0; k <= D; k++) s += 8 * p10(k + D) + 3 * 1111 * p10(k);
        s = (p10(2*D+1) - (s % p10(2*D+1))) % p10(2*D+1);
        for (int p = 0; p < 2*D+1; p++) exp_corr[4*p +: 4] = 4'((s / p10(p)) % 10);
        check("R7", longint'(corr_bcd), longint'(exp_corr), "correction word");

        // Directed chains of the recoder (R1) and corner rows.
        run_valid(0, 0, "R4");
        run_valid(9999, 9999, "R1");
        run_valid(9999, 6666, "R1");
        run_valid(8765, 5555, "R1");
        run_valid(4321, 4545, "R1");
        run_valid(1234, 5959, "R1");
        run_valid(9999, 1000, "");

        // Random valid operands.
        for (int i = 0; i < 300; i++)
            run_valid(int'($urandom % 10000), int'($urandom % 10000), "");

        // Random arbitrary codes: selection and inversion only.
        for (int i = 0; i < 300; i++) begin
            @(posedge clk);
            mplr_bcd = dec2bcd(int'($urandom % 10000));
            mult_xs3 = {$urandom, $urandom, $urandom};
            for (int n = 0; n < 5; n++) mult_carry[3*n +: 3] = 3'($urandom % 5);
            recode(mplr_bcd);
            #2;
            check_rows("R2");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule